// File: doc/BRIEF.md
# DDR Dual-Channel ADC Capture Packer

This block drives the sample clock of a dual-channel 12-bit converter and captures the converter's shared 12-bit output bus. The converter puts one channel on the bus while its clock is high and the other while it is low, so a full period of the generated clock carries two samples. The generated clock runs at one quarter of the system clock. Each of its phases lasts two system clocks, and the same level is driven on two pins, one per converter channel.

Samples are taken in groups of four, named A, B, C and D, and alternate high, low, high, low. Sample A is held in a register. Each of the following three samples is joined with one 4-bit slice of A to make a 16-bit word, so every group of four 12-bit samples fills exactly three 16-bit words. The words leave on a valid/ready stream toward a FIFO or DMA engine. The stream does not apply back-pressure: when the sink is not ready, the word is lost and a sticky flag records the loss. When enable is low, the clock is parked low, and capture always starts again at sample A.

Top module: `ddr_adc_packer`

## Requirements
- R1: While reset is asserted, both clock pins, `word_valid_o` and `overflow_o` are 0.
- R2: While enabled, the ADC clock repeats high for 2 system clocks and then low for 2. Its first high cycle is the cycle after the clock edge at which `en_i` is first seen high.
- R3: Both ADC clock pins carry the same value in every cycle.
- R4: The data bus is sampled at the system clock edge that ends each ADC clock phase. The samples are A (high phase), B (low), C (high) and D (low), and this order repeats.
- R5: The first word of a group is A[3:0] in bits 15:12 and B[11:0] in bits 11:0.
- R6: The second word is A[7:4] in bits 15:12 and C[11:0] in bits 11:0.
- R7: The third word is A[11:8] in bits 15:12 and D[11:0] in bits 11:0.
- R8: `word_valid_o` is a single-cycle pulse in the cycle after the edge that samples B, C or D. No word follows sample A.
- R9: If `en_i` is low at a clock edge, the ADC clock is low in the next cycle. After enable returns, capture restarts at sample A, however far the previous group had got.
- R10: If `word_valid_o` is high while `word_ready_i` is low, that word is dropped and `overflow_o` goes high from the next cycle until reset. The ADC clock keeps running.
- R11: Values on the data bus between sampling edges have no effect on the output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for clock generation and capture |
| adc_data_i | input | 12 | Shared converter data bus |
| adc_clk_o | output | 2 | ADC clock, one identical copy per channel |
| word_o | output | 16 | Packed output word |
| word_valid_o | output | 1 | Word valid pulse |
| word_ready_i | input | 1 | Sink ready |
| overflow_o | output | 1 | Sticky flag for a dropped word |

## Verification
In every cycle the assertions check that the two clock pins agree, that a rising clock lasts two cycles while enabled, that the clock drops one cycle after enable falls, that each valid pulse lasts one cycle, and that the overflow flag is set by a refused word and then stays set. The bit layout of each of the three words, the sampling edge, the fact that bus values between sampling edges are ignored, and the restart at sample A after enable is dropped mid-group can only be shown by the bench. It drives a bus value that changes every cycle and compares each output against a behavioural model on every clock.

// File: rtl/ddr_adc_pkg.sv
package ddr_adc_pkg;
  localparam int unsigned SAMPLE_W_DEF = 12;
  localparam int unsigned WORD_W_DEF   = 16;
  localparam int unsigned HALF_CYC_DEF = 2;
  localparam int unsigned CLK_PINS_DEF = 2;

  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} adc_phase_e;
endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen
  import ddr_adc_pkg::*;
#(
  parameter int unsigned HALF_CYC = HALF_CYC_DEF,
  parameter int unsigned CLK_PINS = CLK_PINS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  output logic [CLK_PINS-1:0] adc_clk_o,
  output logic                run_o,
  output logic                strobe_o
);
  localparam int unsigned PERIOD = 2 * HALF_CYC;
  localparam int unsigned POS_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [POS_W-1:0] POS_LAST_HI = POS_W'(HALF_CYC - 1);
  localparam logic [POS_W-1:0] POS_LAST    = POS_W'(PERIOD - 1);
  localparam logic [POS_W-1:0] POS_HALF    = POS_W'(HALF_CYC);

  logic             run_q, run_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             clk_q;
  adc_phase_e       phase;

  always_comb begin
    run_d = en_i;
    if (!run_q)               pos_d = '0;
    else if (pos_q == POS_LAST) pos_d = '0;
    else                      pos_d = pos_q + 1'b1;
  end

  // clock level registered so the pins never glitch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pos_q <= '0;
      clk_q <= 1'b0;
    end else begin
      run_q <= run_d;
      pos_q <= pos_d;
      clk_q <= run_d && (pos_d < POS_HALF);
    end
  end

  assign phase    = (pos_q < POS_HALF) ? PH_HIGH : PH_LOW;
  assign run_o    = run_q;
  assign strobe_o = run_q && (((phase == PH_HIGH) && (pos_q == POS_LAST_HI)) ||
                              ((phase == PH_LOW)  && (pos_q == POS_LAST)));

  for (genvar g = 0; g < CLK_PINS; g++) begin : g_pin
    assign adc_clk_o[g] = clk_q;
  end
endmodule

// File: rtl/sample_packer.sv
module sample_packer
  import ddr_adc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned WORD_W   = WORD_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                strobe_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic [WORD_W-1:0]   word_o,
  output logic                word_stb_o
);
  localparam int unsigned NIB_W     = WORD_W - SAMPLE_W;
  localparam int unsigned NUM_WORDS = SAMPLE_W / NIB_W;
  localparam int unsigned NUM_SLOTS = NUM_WORDS + 1;
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [SAMPLE_W-1:0] head_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [NIB_W-1:0]    nib;
  logic [WORD_W-1:0]   word_q;
  logic                stb_q;

  // slice of the held sample belonging to the current slot, low slice first
  always_comb begin
    nib = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (slot_q == SLOT_W'(i + 1)) nib = head_q[i*NIB_W +: NIB_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      slot_q <= '0;
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (!run_i) begin
        slot_q <= '0;
      end else if (strobe_i) begin
        if (slot_q == '0) begin
          head_q <= data_i;
        end else begin
          word_q <= {nib, data_i};
          stb_q  <= 1'b1;
        end
        slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign word_o     = word_q;
  assign word_stb_o = stb_q;
endmodule

// File: rtl/ddr_adc_packer.sv
module ddr_adc_packer
  import ddr_adc_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned HALF_CYC = HALF_CYC_DEF,
  parameter int unsigned CLK_PINS = CLK_PINS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic [CLK_PINS-1:0] adc_clk_o,
  output logic [WORD_W-1:0]   word_o,
  output logic                word_valid_o,
  input  logic                word_ready_i,
  output logic                overflow_o
);
  logic run, strobe, ovf_q;

  adc_clk_gen #(
    .HALF_CYC(HALF_CYC),
    .CLK_PINS(CLK_PINS)
  ) i_clk_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .adc_clk_o(adc_clk_o),
    .run_o    (run),
    .strobe_o (strobe)
  );

  sample_packer #(
    .SAMPLE_W(SAMPLE_W),
    .WORD_W  (WORD_W)
  ) i_packer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .strobe_i  (strobe),
    .data_i    (adc_data_i),
    .word_o    (word_o),
    .word_stb_o(word_valid_o)
  );

  // no back-pressure: refused word is lost, loss is remembered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ovf_q <= 1'b0;
    else if (word_valid_o && !word_ready_i) ovf_q <= 1'b1;
  end

  assign overflow_o = ovf_q;
endmodule

// File: rtl/ddr_adc_packer_chk.sv
module ddr_adc_packer_chk #(
  parameter int unsigned CLK_PINS = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                word_ready_i,
  input logic [CLK_PINS-1:0] adc_clk_o,
  input logic                word_valid_o,
  input logic                overflow_o
);
  AST_CLK_PINS_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_clk_o == {CLK_PINS{adc_clk_o[0]}})); // R3

  AST_CLK_HIGH_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(adc_clk_o[0]) && en_i) |=> adc_clk_o[0]); // R2

  AST_CLK_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !adc_clk_o[0]); // R9

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o); // R8

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !word_ready_i) |=> overflow_o); // R10

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R10
endmodule

bind ddr_adc_packer ddr_adc_packer_chk #(.CLK_PINS(CLK_PINS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .word_ready_i(word_ready_i),
  .adc_clk_o   (adc_clk_o),
  .word_valid_o(word_valid_o),
  .overflow_o  (overflow_o)
);

// File: tb/test_ddr_adc_packer.sv
module test_ddr_adc_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        ready = 1'b1;
  logic [11:0] data = '0;
  logic [1:0]  adc_clk;
  logic [15:0] word;
  logic        valid, ovf;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit          m_run = 0;
  int          m_pos = 0;
  int          m_slot = 0;
  int          m_wslot = 0;
  logic [11:0] m_a = '0;
  bit          m_valid = 0;
  bit          m_ovf = 0;
  logic [15:0] m_word = '0;

  always #5 clk = ~clk;

  ddr_adc_packer i_ddr_adc_packer (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .adc_data_i(data),
    .adc_clk_o(adc_clk), .word_o(word), .word_valid_o(valid),
    .word_ready_i(ready), .overflow_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_slot = 0; m_valid = 0; m_ovf = 0;
    end else begin
      bit stb;
      if (m_valid && !ready) m_ovf = 1;
      stb = m_run && (m_pos == 1 || m_pos == 3);
      m_valid = 0;
      if (stb) begin
        case (m_slot)
          0: m_a = data;
          1: begin m_word = {m_a[3:0], data};  m_valid = 1; m_wslot = 1; end
          2: begin m_word = {m_a[7:4], data};  m_valid = 1; m_wslot = 2; end
          default: begin m_word = {m_a[11:8], data}; m_valid = 1; m_wslot = 3; end
        endcase
        m_slot = (m_slot + 1) % 4;
      end
      if (m_run) m_pos = (m_pos + 1) % 4;
      else begin m_pos = 0; m_slot = 0; end
      m_run = en;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      string wtag;
      bit exp_clk;
      exp_clk = m_run && (m_pos < 2);
      chk(adc_clk[0] == exp_clk, "R2 clock level", 32'(adc_clk[0]), 32'(exp_clk));
      chk(adc_clk[1] == adc_clk[0], "R3 pin match", 32'(adc_clk[1]), 32'(adc_clk[0]));
      chk(valid == m_valid, "R8 valid pulse", 32'(valid), 32'(m_valid));
      if (m_valid) begin
        case (m_wslot)
          1: wtag = "R5 word0 (R4 R11)";
          2: wtag = "R6 word1 (R4 R11)";
          default: wtag = "R7 word2 (R4 R11)";
        endcase
        chk(word == m_word, wtag, 32'(word), 32'(m_word));
      end
      chk(ovf == m_ovf, "R10 overflow", 32'(ovf), 32'(m_ovf));
      cyc++;
      data <= 12'((cyc * 1103 + 677) & 12'hfff);
    end
  end

  initial begin
    #12;
    chk(adc_clk == 2'b00, "R1 reset clock", 32'(adc_clk), 0);
    chk(valid == 1'b0, "R1 reset valid", 32'(valid), 0);
    chk(ovf == 1'b0, "R1 reset overflow", 32'(ovf), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (120) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(adc_clk[0] == 1'b0, "R9 clock parked", 32'(adc_clk[0]), 0);
    repeat (5) @(negedge clk);
    en = 1'b1;
    repeat (7) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (13) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (60) @(negedge clk);
    chk(ovf == 1'b0, "R10 no loss while ready", 32'(ovf), 0);
    for (int i = 0; i < 80; i++) begin
      ready = (i % 5) != 0;
      @(negedge clk);
    end
    ready = 1'b1;
    repeat (40) @(negedge clk);
    chk(ovf == 1'b1, "R10 sticky after loss", 32'(ovf), 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule